// File: doc/BRIEF.md
# Warp Load Coalescer

This block takes one load request issued on behalf of a whole group of lanes. Each lane brings a byte address for one 4-byte element and an active flag. The block sorts the active lanes into aligned 128-byte memory segments and sends one memory transaction for each distinct segment. Each transaction carries the segment base address and a lane mask that marks the lanes it serves.

Transactions leave one per cycle on a valid/ready handshake. A new request is taken only once the final transaction of the current one has been accepted. When a request finishes, the block pulses its transaction count for that request.

Inside a request the block works greedily. The lowest-numbered lane that is still waiting becomes the leader. Every waiting lane whose address shares the leader's segment is served by the same transaction and retired together with it.

Top module: `warp_coalescer`

## Requirements
- R1: After reset `req_ready` is 1 and `txn_valid` and `done_valid` are 0. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays 0 from the cycle after acceptance until the final transaction (or the empty completion) has been signalled, and it is 1 again on the following cycle.
- R2: `txn_base` is the leader lane's address with its low log2(SEG_BYTES) bits (7 bits for 128-byte segments) cleared, so every transaction is segment aligned.
- R3: Bit i of `txn_mask` is 1 exactly when lane i is active, has not yet been served, and its address lies in the same segment as the leader's.
- R4: Transactions come out in ascending order of leader lane number, whatever the numeric order of their addresses.
- R5: Lanes reading consecutive 4-byte elements that all fall in one aligned segment produce exactly one transaction with every active lane set. A consecutive run that crosses one segment boundary produces two.
- R6: With all 32 lanes active, a base of 0 and a lane stride of s elements, the transaction count is floor(124*s/128)+1 when 4*s < 128 and 32 otherwise. A stride of 2 gives 2 and a stride of 32 gives 32.
- R7: When all lanes use the same address, one transaction serves every active lane.
- R8: Inactive lanes never appear in any mask. A request with no active lanes produces no transaction, and its done pulse with count 0 comes on the cycle after acceptance.
- R9: While `txn_valid` is 1 and `txn_ready` is 0, the offered transaction stays valid with `txn_base` and `txn_mask` unchanged.
- R10: `done_valid` is 1 for exactly one cycle per request: the cycle on which the final transaction is accepted, or the empty completion. On that cycle `done_count` equals the number of transactions issued for the request.
- R11: No lane is set in two transactions of a request, and the union of all masks of a request equals its active set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, can take a request |
| req_addr | input | LANES*ADDR_W | Per-lane byte addresses; lane i at bits [i*ADDR_W +: ADDR_W] |
| req_active | input | LANES | Per-lane active flags |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Memory side accepts the transaction |
| txn_base | output | ADDR_W | Aligned segment base address |
| txn_mask | output | LANES | Lanes served by this transaction |
| done_valid | output | 1 | Request completed this cycle |
| done_count | output | $clog2(LANES+1) | Transactions issued for the request |

## Verification
The bench builds the block with 32 lanes, 16-bit addresses and 128-byte segments. This keeps the full lane count of the stride rules while letting small random address ranges produce frequent segment collisions. With this configuration every element stride from 1 to 40 can be swept against the closed-form count. It also brings within reach both the single-segment and the one-transaction-per-lane extremes, partially active and empty requests, and leader order that runs against address order, all under back-pressure on the transaction handshake.

// File: rtl/coal_pkg.sv
package coal_pkg;
   localparam int ELEM_BYTES = 4;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/coal_leader.sv
module coal_leader #(
   parameter int LANES = 32,
   localparam int IDX_W = $clog2(LANES)
) (
   input  logic [LANES-1:0] pend,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = |pend;
      idx = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (pend[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/coal_seg_match.sv
module coal_seg_match #(
   parameter int LANES  = 32,
   parameter int ADDR_W = 32,
   parameter int OFS    = 7,
   localparam int IDX_W = $clog2(LANES),
   localparam int SEG_W = ADDR_W - OFS
) (
   input  logic [LANES*SEG_W-1:0] seg_flat,
   input  logic [LANES-1:0]       pend,
   input  logic [IDX_W-1:0]       lead,
   output logic [SEG_W-1:0]       lead_seg,
   output logic [LANES-1:0]       hit
);
   assign lead_seg = seg_flat[lead*SEG_W +: SEG_W];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign hit[g] = pend[g] && (seg_flat[g*SEG_W +: SEG_W] == lead_seg);
   end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
   parameter int LANES     = 32,
   parameter int ADDR_W    = 32,
   parameter int SEG_BYTES = 128,
   localparam int OFS   = $clog2(SEG_BYTES),
   localparam int SEG_W = ADDR_W - OFS,
   localparam int IDX_W = $clog2(LANES),
   localparam int CNT_W = $clog2(LANES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [LANES*ADDR_W-1:0] req_addr,
   input  logic [LANES-1:0]        req_active,
   output logic                    txn_valid,
   input  logic                    txn_ready,
   output logic [ADDR_W-1:0]       txn_base,
   output logic [LANES-1:0]        txn_mask,
   output logic                    done_valid,
   output logic [CNT_W-1:0]        done_count
);
   import coal_pkg::*;

   // elaboration-time parameter checks
   if (LANES < 2) begin : g_bad_lanes
      $error("LANES must be at least 2");
   end
   if (!is_pow2(SEG_BYTES) || SEG_BYTES < ELEM_BYTES) begin : g_bad_seg
      $error("SEG_BYTES must be a power of two no smaller than one element");
   end
   if (ADDR_W <= OFS) begin : g_bad_addr
      $error("ADDR_W must exceed the segment offset width");
   end

   logic                   busy_q;
   logic [LANES-1:0]       pend_q;
   logic [LANES*SEG_W-1:0] seg_q;
   logic [LANES*SEG_W-1:0] seg_in;
   logic [CNT_W-1:0]       cnt_q;

   // only segment numbers are stored; the in-segment offset never matters
   for (genvar g = 0; g < LANES; g++) begin : g_cap
      assign seg_in[g*SEG_W +: SEG_W] = req_addr[g*ADDR_W + OFS +: SEG_W];
   end

   logic             any_pend;
   logic [IDX_W-1:0] lead_idx;
   logic [SEG_W-1:0] lead_seg;
   logic [LANES-1:0] hit;

   coal_leader #(.LANES(LANES)) leader_i (
      .pend (pend_q),
      .any  (any_pend),
      .idx  (lead_idx)
   );

   coal_seg_match #(.LANES(LANES), .ADDR_W(ADDR_W), .OFS(OFS)) match_i (
      .seg_flat (seg_q),
      .pend     (pend_q),
      .lead     (lead_idx),
      .lead_seg (lead_seg),
      .hit      (hit)
   );

   logic             take;
   logic             fire;
   logic [LANES-1:0] pend_nx;

   assign req_ready  = !busy_q;
   assign take       = req_valid && req_ready;
   assign txn_valid  = busy_q && any_pend;
   assign txn_base   = {lead_seg, {OFS{1'b0}}};
   assign txn_mask   = hit;
   assign fire       = txn_valid && txn_ready;
   assign pend_nx    = pend_q & ~hit;
   assign done_valid = busy_q && (!any_pend || (fire && (pend_nx == '0)));
   assign done_count = any_pend ? cnt_q + CNT_W'(1) : cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pend_q <= '0;
         seg_q  <= '0;
         cnt_q  <= '0;
      end else if (take) begin
         busy_q <= 1'b1;
         pend_q <= req_active;
         seg_q  <= seg_in;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (fire) begin
            pend_q <= pend_nx;
            cnt_q  <= cnt_q + CNT_W'(1);
         end
         if (done_valid) busy_q <= 1'b0;
      end
   end
endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
   parameter int LANES     = 32,
   parameter int ADDR_W    = 32,
   parameter int SEG_BYTES = 128,
   localparam int OFS   = $clog2(SEG_BYTES),
   localparam int CNT_W = $clog2(LANES + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              txn_valid,
   input logic              txn_ready,
   input logic [ADDR_W-1:0] txn_base,
   input logic [LANES-1:0]  txn_mask,
   input logic              done_valid,
   input logic [CNT_W-1:0]  done_count
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> !req_ready);

   assert_base_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> (txn_base[OFS-1:0] == '0));

   assert_mask_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> (txn_mask != '0));

   assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_mask)));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   assert_done_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (done_count <= CNT_W'(LANES)));

   assert_lane_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_ready) |=> (!txn_valid || ((txn_mask & $past(txn_mask)) == '0)));
endmodule

bind warp_coalescer warp_coalescer_chk #(
   .LANES(LANES), .ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .txn_valid  (txn_valid),
   .txn_ready  (txn_ready),
   .txn_base   (txn_base),
   .txn_mask   (txn_mask),
   .done_valid (done_valid),
   .done_count (done_count)
);

// File: tb/warp_coalescer_tb_top.sv
module warp_coalescer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LANES      = 32;
   localparam int ADDR_W     = 16;
   localparam int SEG_BYTES  = 128;
   localparam int OFS        = $clog2(SEG_BYTES);
   localparam int CNT_W      = $clog2(LANES + 1);

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    req_valid = 1'b0;
   logic                    req_ready;
   logic [LANES*ADDR_W-1:0] req_addr = '0;
   logic [LANES-1:0]        req_active = '0;
   logic                    txn_valid;
   logic                    txn_ready = 1'b0;
   logic [ADDR_W-1:0]       txn_base;
   logic [LANES-1:0]        txn_mask;
   logic                    done_valid;
   logic [CNT_W-1:0]        done_count;

   always #(CLK_PERIOD/2) clk = ~clk;

   warp_coalescer #(.LANES(LANES), .ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)) dut_i (.*);

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [ADDR_W-1:0] la [LANES];
   logic [LANES-1:0]  lact;
   logic [ADDR_W-1:0] eb [LANES];
   logic [LANES-1:0]  em [LANES];
   int                en;
   logic [31:0]       lfsr = 32'h1ACE_B00C;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
   endtask

   // expected transaction list from the requirements (R2, R3, R4)
   task automatic build_exp();
      logic [LANES-1:0] pend;
      pend = lact;
      en = 0;
      while (pend != '0) begin
         int l;
         logic [LANES-1:0] m;
         l = 0;
         while (!pend[l]) l++;
         m = '0;
         for (int i = 0; i < LANES; i++)
            if (pend[i] && ((la[i] >> OFS) == (la[l] >> OFS))) m[i] = 1'b1;
         eb[en] = (la[l] >> OFS) << OFS;
         em[en] = m;
         en++;
         pend &= ~m;
      end
   endtask

   task automatic run_req(input string tag, input bit stall, input int exp_n);
      int  k;
      int  cyc;
      bit  fin;
      bit  rdy;
      build_exp();
      if (exp_n >= 0) check(en == exp_n, tag, "formula count", en, exp_n);
      @(negedge clk);
      check(req_ready == 1'b1, "R1", "ready when idle", req_ready, 1);
      req_valid = 1'b1;
      req_active = lact;
      for (int i = 0; i < LANES; i++) req_addr[i*ADDR_W +: ADDR_W] = la[i];
      @(negedge clk);
      req_valid = 1'b0;
      req_active = '0;
      k = 0; cyc = 0; fin = 1'b0;
      while (!fin) begin
         check(req_ready == 1'b0, "R1", "busy not ready", req_ready, 0);
         rdy = !(stall && (cyc % 3 == 1));
         txn_ready = rdy;
         #1;
         if (en == 0) begin
            check(txn_valid == 1'b0, "R8", "no txn for empty", txn_valid, 0);
            check(done_valid && done_count == 0, "R8", "empty done", done_count, 0);
            fin = 1'b1;
         end else begin
            check(txn_valid == 1'b1, "R4", {tag, " txn offered"}, txn_valid, 1);
            check(txn_base == eb[k], "R2", {tag, " base"}, txn_base, eb[k]);
            check(txn_mask == em[k], "R3", {tag, " mask"}, txn_mask, em[k]);
            if (rdy) begin
               k++;
               if (k == en) begin
                  check(done_valid == 1'b1, "R10", {tag, " done pulse"}, done_valid, 1);
                  check(done_count == CNT_W'(en), "R10", {tag, " done count"}, done_count, en);
                  fin = 1'b1;
               end else
                  check(done_valid == 1'b0, "R10", {tag, " early done"}, done_valid, 0);
            end else
               check(done_valid == 1'b0, "R9", {tag, " done in stall"}, done_valid, 0);
         end
         cyc++;
         @(negedge clk);
         txn_ready = 1'b0;
      end
      check(req_ready == 1'b1, "R1", "ready after done", req_ready, 1);
      check(done_valid == 1'b0, "R10", "done one cycle", done_valid, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
      check(txn_valid == 1'b0, "R1", "reset txn_valid", txn_valid, 0);
      check(done_valid == 1'b0, "R1", "reset done_valid", done_valid, 0);
      rst_n = 1'b1;

      lact = '1;
      for (int i = 0; i < LANES; i++) la[i] = ADDR_W'(16'h0200 + 4*i);
      run_req("R5", 1'b0, 1);
      for (int i = 0; i < LANES; i++) la[i] = ADDR_W'(16'h0240 + 4*i);
      run_req("R5", 1'b1, 2);
      for (int i = 0; i < LANES; i++) la[i] = ADDR_W'(16'h0400 + 8*i);
      run_req("R6", 1'b0, 2);
      for (int i = 0; i < LANES; i++) la[i] = ADDR_W'(128*i);
      run_req("R6", 1'b1, 32);
      for (int i = 0; i < LANES; i++) la[i] = 16'h0ABC;
      run_req("R7", 1'b1, 1);

      // leader order against address order
      for (int i = 0; i < LANES; i++) la[i] = ADDR_W'((3 - i % 4) * 128 + 4*i);
      run_req("R4", 1'b1, 4);

      // partial and empty activity
      lact = 32'hF0F0_0F0F;
      for (int i = 0; i < LANES; i++) la[i] = ADDR_W'(16'h0200 + 4*i);
      run_req("R8", 1'b0, 1);
      for (int i = 0; i < LANES; i++) la[i] = ADDR_W'(128*i);
      run_req("R8", 1'b1, 16);
      lact = '0;
      run_req("R8", 1'b0, 0);

      // stride sweep against closed form
      lact = '1;
      for (int s = 1; s <= 40; s++) begin
         for (int i = 0; i < LANES; i++) la[i] = ADDR_W'(4*s*i);
         run_req("R6", s[0], (4*s < 128) ? (124*s)/128 + 1 : 32);
      end

      // scattered addresses in small ranges
      for (int t = 0; t < 60; t++) begin
         step_lfsr();
         lact = lfsr;
         for (int i = 0; i < LANES; i++) begin
            step_lfsr();
            la[i] = ADDR_W'(lfsr[11:0] & ((t % 2 == 0) ? 12'h3FC : 12'hFFC));
         end
         run_req("R11", t[0], -1);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule